// File: doc/BRIEF.md
# Shared-Bus Three-Register Transfer Unit

The block holds three equal-width storage words that exchange data over one common bus. A two-bit source code picks what drives the bus: one of the three words or a word supplied from outside the block. Each storage word has its own load line. On a rising edge, every word whose load line is high captures the bus value. Every word whose load line is low recirculates its own contents through a feedback multiplexer.

The clock runs freely and is never gated, so all words share one clock tree with no added skew. The bus value is brought out on every cycle so that the surrounding logic can observe it. Because only one source can reach the bus in a cycle, moving data between words is done as a sequence of single-source transfers. For example, exchanging two words takes three cycles and uses the third word as scratch space.

Top module: `xfer_bus_regfile`

## Requirements
- R1: While `rst_n` is low, all three stored words read zero.
- R2: With `sel_i` equal to 0, 1 or 2, `bus_o` shows word 0, word 1 or word 2 respectively in the same cycle.
- R3: With `sel_i` equal to 3, `bus_o` shows `ext_i` in the same cycle.
- R4: A word whose `load_i` bit is 1 at a rising edge holds, after that edge, the value `bus_o` had before the edge. Bit k of `load_i` belongs to word k.
- R5: A word whose `load_i` bit is 0 at a rising edge keeps its value across that edge.
- R6: All words loaded at the same edge receive the same bus value.
- R7: Loading a word from itself (the source code equals the destination index) leaves its value unchanged.
- R8: A three-cycle exchange of two words through the third word swaps the two, and no word that is not loaded in a given cycle changes in that cycle.
- R9: `bus_o` follows `sel_i` on every cycle, including cycles where no load bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel_i | input | 2 | Bus source code: 0..2 select a word, 3 selects ext_i |
| load_i | input | 3 | Per-word load enables, bit k for word k |
| ext_i | input | WIDTH | External word placed on the bus when sel_i is 3 |
| reg0_o | output | WIDTH | Contents of word 0 |
| reg1_o | output | WIDTH | Contents of word 1 |
| reg2_o | output | WIDTH | Contents of word 2 |
| bus_o | output | WIDTH | Current bus value |

## Verification
The bus is purely combinational, so the bench checks `bus_o` shortly after it changes the inputs, within the same cycle and before the next rising edge. Stored words pass through a single register stage. The bench therefore checks them at the falling edge that follows the loading rising edge, against a model it updates with the bus value it predicted before that edge. The bench drives inputs on falling edges only, which leaves half a period of settling before each capturing edge.

// File: rtl/xfer_bus_pkg.sv
package xfer_bus_pkg;
    localparam int NUM_WORDS = 3;
    localparam int SEL_W     = 2;
    localparam int NUM_SRC   = NUM_WORDS + 1;

    typedef enum logic [SEL_W-1:0] {
        SRC_W0  = 2'd0,
        SRC_W1  = 2'd1,
        SRC_W2  = 2'd2,
        SRC_EXT = 2'd3
    } src_sel_e;
endpackage

// File: rtl/xfer_bus_mux.sv
module xfer_bus_mux
    import xfer_bus_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [NUM_SRC-1:0][WIDTH-1:0] src_i,
    input  logic [SEL_W-1:0]              sel_i,
    output logic [WIDTH-1:0]              bus_o
);
    always_comb begin
        bus_o = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (int'(sel_i) == i) begin
                bus_o = src_i[i];
            end
        end
    end
endmodule

// File: rtl/xfer_reg_cell.sv
module xfer_reg_cell #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [WIDTH-1:0] din_i,
    output logic [WIDTH-1:0] q_o
);
    typedef struct packed {
        logic [WIDTH-1:0] word;
    } cell_state_t;

    cell_state_t state_d, state_q;

    // feedback multiplexer: hold by recirculation, clock never gated
    always_comb begin
        state_d = state_q;
        if (load_i) begin
            state_d.word = din_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign q_o = state_q.word;
endmodule

// File: rtl/xfer_bus_regfile.sv
module xfer_bus_regfile
    import xfer_bus_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [SEL_W-1:0]     sel_i,
    input  logic [NUM_WORDS-1:0] load_i,
    input  logic [WIDTH-1:0]     ext_i,
    output logic [WIDTH-1:0]     reg0_o,
    output logic [WIDTH-1:0]     reg1_o,
    output logic [WIDTH-1:0]     reg2_o,
    output logic [WIDTH-1:0]     bus_o
);
    logic [NUM_WORDS-1:0][WIDTH-1:0] word_q;
    logic [NUM_SRC-1:0][WIDTH-1:0]   src;
    logic [WIDTH-1:0]                bus;

    always_comb begin
        for (int i = 0; i < NUM_WORDS; i++) begin
            src[i] = word_q[i];
        end
        src[NUM_SRC-1] = ext_i;
    end

    xfer_bus_mux #(.WIDTH(WIDTH)) u_mux (
        .src_i (src),
        .sel_i (sel_i),
        .bus_o (bus)
    );

    for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
        xfer_reg_cell #(.WIDTH(WIDTH)) u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .load_i (load_i[g]),
            .din_i  (bus),
            .q_o    (word_q[g])
        );
    end

    assign reg0_o = word_q[0];
    assign reg1_o = word_q[1];
    assign reg2_o = word_q[2];
    assign bus_o  = bus;
endmodule

// File: rtl/xfer_bus_checker.sv
module xfer_bus_checker #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       sel_i,
    input logic [2:0]       load_i,
    input logic [WIDTH-1:0] ext_i,
    input logic [WIDTH-1:0] reg0_o,
    input logic [WIDTH-1:0] reg1_o,
    input logic [WIDTH-1:0] reg2_o,
    input logic [WIDTH-1:0] bus_o
);
    assert_bus_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i == 2'd0 |-> bus_o == reg0_o) and (sel_i == 2'd1 |-> bus_o == reg1_o)
        and (sel_i == 2'd2 |-> bus_o == reg2_o));

    assert_bus_ext_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sel_i == 2'd3 |-> bus_o == ext_i);

    assert_load_w0_R4: assert property (@(posedge clk) disable iff (!rst_n)
        load_i[0] |=> reg0_o == $past(bus_o));
    assert_load_w1_R4: assert property (@(posedge clk) disable iff (!rst_n)
        load_i[1] |=> reg1_o == $past(bus_o));
    assert_load_w2_R4: assert property (@(posedge clk) disable iff (!rst_n)
        load_i[2] |=> reg2_o == $past(bus_o));

    assert_hold_w0_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i[0] |=> $stable(reg0_o));
    assert_hold_w1_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i[1] |=> $stable(reg1_o));
    assert_hold_w2_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i[2] |=> $stable(reg2_o));

    assert_same_value_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i[0] && load_i[1]) |=> reg0_o == reg1_o);

    assert_self_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i == 2'd1 && load_i[1]) |=> $stable(reg1_o));
endmodule

bind xfer_bus_regfile xfer_bus_checker #(.WIDTH(WIDTH)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .sel_i  (sel_i),
    .load_i (load_i),
    .ext_i  (ext_i),
    .reg0_o (reg0_o),
    .reg1_o (reg1_o),
    .reg2_o (reg2_o),
    .bus_o  (bus_o)
);

// File: tb/xfer_bus_regfile_tb.sv
module xfer_bus_regfile_tb;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   sel = 2'd0;
    logic [2:0]   load = 3'b000;
    logic [W-1:0] ext = '0;
    logic [W-1:0] r0, r1, r2, bus;

    int n_tests = 0;
    int n_fail  = 0;
    logic [W-1:0] model [3];

    always #5 clk = ~clk;

    xfer_bus_regfile #(.WIDTH(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .sel_i(sel), .load_i(load), .ext_i(ext),
        .reg0_o(r0), .reg1_o(r1), .reg2_o(r2), .bus_o(bus)
    );

    task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] src_val(logic [1:0] s, logic [W-1:0] e);
        return (s == 2'd3) ? e : model[s];
    endfunction

    task automatic check_words(string req);
        check(req, r0, model[0]);
        check(req, r1, model[1]);
        check(req, r2, model[2]);
    endtask

    // one cycle: drive at falling edge, check bus, clock, check words
    task automatic step(logic [1:0] s, logic [2:0] l, logic [W-1:0] e, string req);
        logic [W-1:0] exp_bus;
        @(negedge clk);
        sel = s; load = l; ext = e;
        #1;
        exp_bus = src_val(s, e);
        check(req, bus, exp_bus);
        @(posedge clk);
        for (int k = 0; k < 3; k++) if (l[k]) model[k] = exp_bus;
        @(negedge clk);
        check_words(req);
        load = 3'b000;
    endtask

    task automatic t_reset();
        for (int k = 0; k < 3; k++) model[k] = '0;
        #1;
        check_words("R1");
        repeat (2) @(posedge clk);
        #1;
        rst_n = 1'b1;
        check_words("R1");
    endtask

    task automatic t_ext_load();
        step(2'd3, 3'b001, 8'hA5, "R3");
        step(2'd3, 3'b010, 8'h3C, "R4");
        step(2'd3, 3'b100, 8'hF0, "R4");
    endtask

    task automatic t_bus_select();
        step(2'd0, 3'b000, 8'h00, "R2");
        step(2'd1, 3'b000, 8'h11, "R2");
        step(2'd2, 3'b000, 8'h22, "R9");
        step(2'd3, 3'b000, 8'h77, "R9");
    endtask

    task automatic t_hold();
        step(2'd3, 3'b000, 8'hEE, "R5");
        step(2'd0, 3'b100, 8'h00, "R5");
    endtask

    task automatic t_multi_load();
        step(2'd3, 3'b111, 8'h5A, "R6");
        step(2'd3, 3'b001, 8'h81, "R6");
        step(2'd0, 3'b110, 8'h00, "R6");
    endtask

    task automatic t_self_load();
        step(2'd3, 3'b010, 8'hC3, "R7");
        step(2'd1, 3'b010, 8'h00, "R7");
        step(2'd2, 3'b100, 8'h00, "R7");
    endtask

    task automatic t_swap();
        logic [W-1:0] a, b;
        step(2'd3, 3'b001, 8'h12, "R8");
        step(2'd3, 3'b010, 8'h34, "R8");
        a = model[0]; b = model[1];
        step(2'd0, 3'b100, 8'h00, "R8");
        step(2'd1, 3'b001, 8'h00, "R8");
        step(2'd2, 3'b010, 8'h00, "R8");
        check("R8", r0, b);
        check("R8", r1, a);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_ext_load();
                t_bus_select();
                t_hold();
                t_multi_load();
                t_self_load();
                t_swap();
            end
            begin
                repeat (5000) @(posedge clk);
                n_tests++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule